// File: doc/BRIEF.md
# Shared-Memory Reservation Monitor

This block keeps the reservation state behind load-locked / store-conditional pairs for several processor ports that share one memory. Each port issues at most one request per cycle. The request carries a valid strobe, a physical address, a store indication, a locked flag and an uncacheable flag. A locked load opens a reservation on a 16-byte granule for its port. A later store-conditional from that port succeeds only while that reservation is still intact.

The monitor answers every cacheable store-conditional in the cycle it is presented, with a completion strobe and a success bit. All reservation changes take effect at the next rising clock edge. Any write that reaches memory clears the reservation of every port holding the written granule, on whichever port the write was issued. These writes are ordinary stores, successful store-conditionals and uncacheable store-conditionals. The data path, caches and address translation are outside the block.

Top module: `llsc_monitor`

## Requirements
- R1: A synchronous active-low reset clears every port's reservation, so a store-conditional issued right after reset reports failure.
- R2: A locked load (valid=1, store=0, locked=1) records its address and arms its port's reservation at the next clock edge. A store-conditional from that port to the same granule then reports sc_done=1 and sc_ok=1 in the same cycle.
- R3: Addresses are compared with bits 3:0 ignored. A store-conditional that differs from the reservation only in those bits succeeds, and one that differs in bit 4 or above fails.
- R4: A cacheable store-conditional that fails reports sc_done=1 and sc_ok=0, and it disarms its own port's reservation.
- R5: A failing store-conditional performs no write, so the reservations of other ports on the same granule stay armed.
- R6: A successful store-conditional disarms every matching reservation, its own included. A second store-conditional to that granule therefore fails.
- R7: An ordinary store (valid=1, store=1, locked=0) disarms every port's reservation on its granule and leaves reservations on other granules armed.
- R8: An uncacheable store-conditional (store=1, locked=1, uncacheable=1) reports sc_done=0 and sc_ok=0, and it invalidates matching reservations like an ordinary store.
- R9: When a locked load and an invalidating store from another port hit the same granule in one cycle, the load's reservation survives.
- R10: Requests in one cycle are resolved in ascending port order. A write from a lower-numbered port defeats a same-granule store-conditional on a higher-numbered port in that cycle. A write from a higher-numbered port does not change a lower-numbered port's result in that cycle, though it still disarms the reservation afterwards.
- R11: Loads without the locked flag leave every reservation unchanged.
- R12: sc_done and sc_ok stay low for every request that is not a valid cacheable store-conditional, including idle ports that present store=1, locked=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_PORTS | Per-port request strobe |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port physical address, port p in bits [p*ADDR_W +: ADDR_W] |
| req_store | input | NUM_PORTS | 1 = store, 0 = load |
| req_locked | input | NUM_PORTS | Locked load or store-conditional |
| req_uncached | input | NUM_PORTS | Uncacheable access |
| sc_done | output | NUM_PORTS | Store-conditional result valid, same cycle |
| sc_ok | output | NUM_PORTS | Store-conditional succeeded, same cycle |

## Verification
The store-conditional outputs are combinational, so they are due in the very cycle the request is presented. The bench drives inputs on the falling edge and samples sc_done and sc_ok 2 ns later, before the next rising edge. Reservation updates land on the following rising edge, so their effect is first visible to a request presented one cycle later. The reference model commits its own state just after that edge. Directed sequences place each probing store-conditional in the cycle right after the stimulus it observes.

// File: rtl/llsc_pkg.sv
// Shared definitions for the reservation monitor.
// Assumes reservations are tracked at a 16-byte granule.
package llsc_pkg;
    localparam int GRAN_LSB = 4;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_LOAD,
        RQ_LOCK,
        RQ_STORE,
        RQ_COND,
        RQ_COND_UC
    } req_kind_e;
endpackage

// File: rtl/llsc_decode.sv
// Classifies one port's request strobes into a single request kind.
// Assumes strobes are meaningful only while valid is high.
module llsc_decode
    import llsc_pkg::*;
(
    input  logic      valid,
    input  logic      store,
    input  logic      locked,
    input  logic      uncached,
    output req_kind_e kind
);
    // Map the strobe combination onto one request kind.
    always_comb begin
        if (!valid)
            kind = RQ_IDLE;
        else if (!store)
            kind = locked ? RQ_LOCK : RQ_LOAD;
        else if (!locked)
            kind = RQ_STORE;
        else
            kind = uncached ? RQ_COND_UC : RQ_COND;
    end
endmodule

// File: rtl/llsc_order.sv
// Resolves one cycle of requests across all ports in ascending port order.
// Produces store-conditional results and per-reservation clear strobes.
// Assumes reservation state is the registered value from the previous edge.
module llsc_order
    import llsc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 48
) (
    input  req_kind_e                    kind      [NUM_PORTS],
    input  logic [NUM_PORTS*ADDR_W-1:0]  req_addr,
    input  logic [NUM_PORTS*ADDR_W-1:0]  resv_addr,
    input  logic [NUM_PORTS-1:0]         resv_flag,
    output logic [NUM_PORTS-1:0]         sc_done,
    output logic [NUM_PORTS-1:0]         sc_ok,
    output logic [NUM_PORTS-1:0]         kill
);
    localparam int TAG_W = ADDR_W - GRAN_LSB;

    function automatic logic same_gran(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:GRAN_LSB] == b[ADDR_W-1:GRAN_LSB];
    endfunction

    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = '0;

    // Walk ports in order; earlier writes shadow later conditional stores.
    always_comb begin
        logic [NUM_PORTS-1:0] wr;
        logic early;
        wr      = '0;
        sc_done = '0;
        sc_ok   = '0;
        kill    = '0;
        for (int j = 0; j < NUM_PORTS; j++) begin
            early = 1'b0;
            for (int i = 0; i < j; i++)
                early = early | (wr[i] & same_gran(req_addr[i*ADDR_W +: ADDR_W],
                                                    resv_addr[j*ADDR_W +: ADDR_W]));
            sc_done[j] = (kind[j] == RQ_COND);
            sc_ok[j]   = (kind[j] == RQ_COND) && resv_flag[j] && !early &&
                         same_gran(req_addr[j*ADDR_W +: ADDR_W], resv_addr[j*ADDR_W +: ADDR_W]);
            wr[j]      = (kind[j] == RQ_STORE) || (kind[j] == RQ_COND_UC) || sc_ok[j];
        end
        for (int j = 0; j < NUM_PORTS; j++) begin
            kill[j] = (kind[j] == RQ_COND) && !sc_ok[j];
            for (int i = 0; i < NUM_PORTS; i++)
                kill[j] = kill[j] | (wr[i] & same_gran(req_addr[i*ADDR_W +: ADDR_W],
                                                       resv_addr[j*ADDR_W +: ADDR_W]));
        end
    end
endmodule

// File: rtl/llsc_entry.sv
// Holds one port's reservation address and armed flag.
// Assumes a new lock takes priority over a same-cycle clear.
module llsc_entry #(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_lock,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              kill,
    output logic              flag_q,
    output logic [ADDR_W-1:0] addr_q
);
    // Armed flag: reset clears, lock arms, clear disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_lock)
            flag_q <= 1'b1;
        else if (kill)
            flag_q <= 1'b0;
    end

    // Reservation address: captured on each locked load, no reset needed.
    always_ff @(posedge clk) begin
        if (set_lock)
            addr_q <= set_addr;
    end

    p_lock_arms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_lock |=> flag_q);
    p_clear_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !set_lock) |=> !flag_q);
    p_idle_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill && !set_lock) |=> $stable(flag_q));
endmodule

// File: rtl/llsc_monitor.sv
// Top of the reservation monitor: decodes each port, resolves the cycle,
// and updates one reservation entry per port.
// Assumes one request per port per cycle; results are combinational.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    input  logic [NUM_PORTS-1:0]        req_store,
    input  logic [NUM_PORTS-1:0]        req_locked,
    input  logic [NUM_PORTS-1:0]        req_uncached,
    output logic [NUM_PORTS-1:0]        sc_done,
    output logic [NUM_PORTS-1:0]        sc_ok
);
    req_kind_e                   kind [NUM_PORTS];
    logic [NUM_PORTS-1:0]        kill;
    logic [NUM_PORTS-1:0]        resv_flag;
    logic [NUM_PORTS*ADDR_W-1:0] resv_addr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        llsc_decode u_dec (
            .valid    (req_valid[p]),
            .store    (req_store[p]),
            .locked   (req_locked[p]),
            .uncached (req_uncached[p]),
            .kind     (kind[p])
        );

        llsc_entry #(.ADDR_W(ADDR_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_lock (kind[p] == RQ_LOCK),
            .set_addr (req_addr[p*ADDR_W +: ADDR_W]),
            .kill     (kill[p]),
            .flag_q   (resv_flag[p]),
            .addr_q   (resv_addr[p*ADDR_W +: ADDR_W])
        );

        p_ok_implies_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
            sc_ok[p] |-> sc_done[p]);
        p_ok_needs_resv_r2: assert property (@(posedge clk) disable iff (!rst_n)
            sc_ok[p] |-> resv_flag[p]);
        p_fail_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sc_done[p] && !sc_ok[p]) |=> !resv_flag[p]);
        p_uc_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_store[p] && req_locked[p] && req_uncached[p]) |-> !sc_done[p]);
    end

    llsc_order #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_order (
        .kind      (kind),
        .req_addr  (req_addr),
        .resv_addr (resv_addr),
        .resv_flag (resv_flag),
        .sc_done   (sc_done),
        .sc_ok     (sc_ok),
        .kill      (kill)
    );
endmodule

// File: tb/tb_llsc_monitor.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// checked against a reference model derived from the requirements.
module tb_llsc_monitor;
    localparam int N  = 4;
    localparam int AW = 48;
    localparam int K_IDLE = 0, K_LOAD = 1, K_LOCK = 2, K_STORE = 3, K_SC = 4, K_SCUC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] v, st, lk, uc;
    logic [AW-1:0] ad [N];
    logic [N*AW-1:0] ad_flat;
    logic [N-1:0] sc_done, sc_ok;

    int vectors = 0, fails = 0;
    logic [N-1:0] mflag;
    logic [AW-1:0] maddr [N];
    logic [N-1:0] edone, eok, nkill;
    logic [N-1:0] want_en, want_d, want_o;

    always #10 clk = ~clk;

    always_comb for (int p = 0; p < N; p++) ad_flat[p*AW +: AW] = ad[p];

    llsc_monitor #(.NUM_PORTS(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_addr(ad_flat),
        .req_store(st), .req_locked(lk), .req_uncached(uc),
        .sc_done(sc_done), .sc_ok(sc_ok)
    );

    function automatic logic gm(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return a[AW-1:4] == b[AW-1:4];
    endfunction

    function automatic int kind_of(input int p);
        if (!v[p]) return K_IDLE;
        if (!st[p]) return lk[p] ? K_LOCK : K_LOAD;
        if (!lk[p]) return K_STORE;
        return uc[p] ? K_SCUC : K_SC;
    endfunction

    // Reference: ascending port order; writes clear matching reservations.
    task automatic model_eval();
        logic [N-1:0] wr;
        logic early;
        wr = '0;
        for (int j = 0; j < N; j++) begin
            early = 1'b0;
            for (int i = 0; i < j; i++) early |= wr[i] & gm(ad[i], maddr[j]);
            edone[j] = (kind_of(j) == K_SC);
            eok[j]   = edone[j] && mflag[j] && !early && gm(ad[j], maddr[j]);
            wr[j]    = (kind_of(j) == K_STORE) || (kind_of(j) == K_SCUC) || eok[j];
        end
        for (int j = 0; j < N; j++) begin
            nkill[j] = edone[j] && !eok[j];
            for (int i = 0; i < N; i++) nkill[j] |= wr[i] & gm(ad[i], maddr[j]);
        end
    endtask

    task automatic check(input string tag, input string what, input int p,
                         input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s port%0d %s: got %b expected %b", tag, p, what, got, exp);
        end
    endtask

    task automatic idle();
        v = '0; st = '0; lk = '0; uc = '0;
        for (int p = 0; p < N; p++) ad[p] = '0;
    endtask

    task automatic rq(input int p, input int k, input logic [AW-1:0] a);
        v[p]  = (k != K_IDLE);
        st[p] = (k == K_STORE) || (k == K_SC) || (k == K_SCUC);
        lk[p] = (k == K_LOCK) || (k == K_SC) || (k == K_SCUC);
        uc[p] = (k == K_SCUC);
        ad[p] = a;
    endtask

    task automatic want(input int p, input logic d, input logic o);
        want_en[p] = 1'b1; want_d[p] = d; want_o[p] = o;
    endtask

    // Called at a falling edge with inputs set; results due this cycle.
    task automatic step(input string tag);
        #2;
        model_eval();
        for (int p = 0; p < N; p++) begin
            check(tag, "sc_done", p, sc_done[p], edone[p]);
            check(tag, "sc_ok", p, sc_ok[p], eok[p]);
            if (want_en[p]) begin
                check(tag, "sc_done(directed)", p, sc_done[p], want_d[p]);
                check(tag, "sc_ok(directed)", p, sc_ok[p], want_o[p]);
            end
        end
        want_en = '0;
        @(posedge clk); #1;
        for (int p = 0; p < N; p++) begin
            if (!rst_n) mflag[p] = 1'b0;
            else if (kind_of(p) == K_LOCK) begin mflag[p] = 1'b1; maddr[p] = ad[p]; end
            else if (nkill[p]) mflag[p] = 1'b0;
        end
        idle();
        @(negedge clk);
    endtask

    localparam logic [AW-1:0] GX = 48'h0000_1234_5670;
    localparam logic [AW-1:0] GY = 48'h0000_1234_5680;
    localparam logic [AW-1:0] GZ = 48'h7FFF_0000_0100;

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        idle(); want_en = '0; mflag = '0;
        for (int p = 0; p < N; p++) maddr[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: arm everything, reset, then every conditional store fails.
        for (int p = 0; p < N; p++) rq(p, K_LOCK, GX);
        step("R1");
        rst_n = 1'b0; step("R1");
        rst_n = 1'b1;
        for (int p = 0; p < N; p++) begin rq(p, K_SC, GX); want(p, 1, 0); end
        step("R1");

        // R2, R3: low nibble ignored; R6: own reservation consumed.
        rq(0, K_LOCK, GX + 3); step("R2");
        rq(0, K_SC, GX + 12); want(0, 1, 1); step("R3");
        rq(0, K_SC, GX); want(0, 1, 0); step("R6");

        // R3, R4: bit-4 difference fails and disarms.
        rq(1, K_LOCK, GX); step("R4");
        rq(1, K_SC, GX + 16); want(1, 1, 0); step("R3");
        rq(1, K_SC, GX); want(1, 1, 0); step("R4");

        // R5: failed conditional store leaves other reservations armed.
        rq(0, K_LOCK, GX); rq(1, K_LOCK, GX); step("R5");
        rq(2, K_SC, GX); want(2, 1, 0); step("R5");
        rq(0, K_SC, GX); want(0, 1, 1); step("R5");
        rq(1, K_SC, GX); want(1, 1, 0); step("R6");

        // R7: plain store clears matching granule only.
        rq(0, K_LOCK, GX); rq(1, K_LOCK, GY); step("R7");
        rq(3, K_STORE, GX + 8); want(3, 0, 0); step("R7");
        rq(0, K_SC, GX); rq(1, K_SC, GY); want(0, 1, 0); want(1, 1, 1); step("R7");

        // R8: uncacheable conditional store is silent but invalidates.
        rq(2, K_LOCK, GZ); step("R8");
        rq(3, K_SCUC, GZ); want(3, 0, 0); step("R8");
        rq(2, K_SC, GZ); want(2, 1, 0); step("R8");

        // R9: same-cycle lock and store on one granule: lock survives.
        rq(1, K_LOCK, GX); rq(0, K_STORE, GX); step("R9");
        rq(1, K_SC, GX); want(1, 1, 1); step("R9");

        // R10: lower port wins; higher-port store does not affect lower result.
        rq(0, K_LOCK, GX); rq(1, K_LOCK, GX); rq(2, K_LOCK, GY); rq(3, K_LOCK, GY); step("R10");
        rq(0, K_SC, GX); rq(1, K_SC, GX); rq(2, K_SC, GY); rq(3, K_STORE, GY);
        want(0, 1, 1); want(1, 1, 0); want(2, 1, 1); want(3, 0, 0); step("R10");
        rq(2, K_SC, GY); want(2, 1, 0); step("R10");

        // R11: plain loads do nothing; R12: idle port with store/locked high.
        rq(0, K_LOCK, GZ); step("R11");
        rq(1, K_LOAD, GZ); rq(0, K_LOAD, GX); want(0, 0, 0); want(1, 0, 0);
        st[2] = 1'b1; lk[2] = 1'b1; ad[2] = GZ; want(2, 0, 0); step("R12");
        rq(0, K_SC, GZ); want(0, 1, 1); step("R11");

        // Random traffic over a few shared granules (R2, R10).
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < N; p++) begin
                int k;
                k = $urandom_range(0, 9);
                if (k > 5) k = (k > 7) ? K_SC : K_LOCK;
                rq(p, k, {32'h0000_0AB0, 12'h0, 4'h0}
                         | AW'({$urandom_range(0, 3), 4'h0})
                         | AW'($urandom_range(0, 15)));
            end
            step("R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule